// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel data word into one asynchronous serial frame on a single output line. A word is offered with `in_valid` and taken on the clock edge where `in_ready` is also high. The line then carries a start bit, 5 to 9 data bits, an optional parity bit and a stop period. After that the line returns to its resting level and the block can take the next word.

Each bit lasts `cfg_div` clocks. The number of data bits, parity kind, stop length, bit order and the two inversion options are run-time inputs. All of them are sampled together with the word, so changing them during a frame has no effect on that frame. The controller is a five-state machine. `S_IDLE` goes to `S_START` on acceptance. `S_START` goes to `S_DATA` when its bit time ends. `S_DATA` stays in `S_DATA` for each further data bit. After the last data bit, `S_DATA` goes to `S_PARITY` when parity is enabled and to `S_STOP` otherwise. `S_PARITY` goes to `S_STOP` when its bit time ends. `S_STOP` goes back to `S_IDLE` when the stop period ends.

Top module: `serial_frame_tx`

## Requirements
- R1: While no frame is in progress, and right after reset, `tx_out` equals NOT `cfg_inv_line`, `busy` is 0 and `in_ready` is 1.
- R2: The start bit begins in the clock cycle after acceptance and lasts one bit time. Its level is `cfg_inv_line`, which is low when line inversion is off.
- R3: The number of data bits is `cfg_len`, with values below 5 taken as 5 and values above 9 taken as 9. Each data bit lasts `cfg_div` clocks. With `cfg_msb_first`=0, `in_data[0]` is sent first. Bits of `in_data` at and above the length are ignored.
- R4: With `cfg_msb_first`=1, the data bits go out from `in_data[len-1]` down to `in_data[0]`.
- R5: The parity bit follows the data bits for one bit time. The encoding of `cfg_parity` is:
  - 0: no parity bit.
  - 1: odd parity (data ones plus the parity bit give an odd count).
  - 2: even parity.
  - 3: parity bit fixed at 1.
  - 4: parity bit fixed at 0.
  - 5 to 7: no parity bit.
- R6: The stop period is at the resting level. Its length for `cfg_stop` values 0, 1, 2 and 3 is D, D + floor(D/2), 2·D and floor(D/2) clocks respectively, where D is the divisor in use.
- R7: `cfg_inv_line`=1 inverts every level on the line, the resting level included. `cfg_inv_data`=1 inverts only the data and parity bits. Parity is computed on the data before inversion.
- R8: `in_ready` is 1 only when no frame is in progress. It is 0 from the cycle after acceptance through the last stop cycle. `busy` is its complement. A word offered while busy is not taken.
- R9: All configuration inputs are captured at acceptance. Changes during a frame do not alter it.
- R10: A `cfg_div` below 2 is taken as 2, so a half-bit stop period always lasts at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The transmitter can take a word |
| in_data | input | MAXB (9) | Word to send |
| cfg_div | input | DIV_W (16) | Clocks per bit |
| cfg_len | input | LW (4) | Number of data bits |
| cfg_parity | input | 3 | Parity kind code |
| cfg_stop | input | 2 | Stop length code |
| cfg_msb_first | input | 1 | Send the highest data bit first |
| cfg_inv_line | input | 1 | Invert the whole line |
| cfg_inv_data | input | 1 | Invert the data and parity bits only |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |

## Verification
Acceptance happens at a rising edge. The start level is due in the very next cycle, and every later segment follows after exactly D, or stop-length, clocks. `in_ready` comes back in the cycle after the last stop clock. When a word is accepted, the driver computes the whole frame from the requirements and queues one expected line level per clock. A monitor samples at each falling edge. While the queue is non-empty it pops one level and also expects `busy`. While the queue is empty it expects the resting level and `in_ready`. Because of this, an error of a single cycle in any bit or stop length shows up as a level mismatch.

// File: rtl/sft_pkg.sv
package sft_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_t;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;
    localparam logic [1:0] STOP_TWO      = 2'd2;
    localparam logic [1:0] STOP_HALF     = 2'd3;
endpackage

// File: rtl/sft_word_prep.sv
module sft_word_prep #(
    parameter int MAXB = 9,
    parameter int MINB = 5,
    localparam int LW = $clog2(MAXB + 1)
) (
    input  logic [MAXB-1:0] word,
    input  logic [LW-1:0]   len_req,
    input  logic            msb_first,
    input  logic [2:0]      par_mode,
    output logic [MAXB-1:0] bits,
    output logic [LW-1:0]   len,
    output logic            par_en,
    output logic            par_bit
);
    import sft_pkg::*;

    logic ones_odd;

    always_comb begin
        if (len_req < LW'(MINB))
            len = LW'(MINB);
        else if (len_req > LW'(MAXB))
            len = LW'(MAXB);
        else
            len = len_req;

        ones_odd = 1'b0;
        for (int i = 0; i < MAXB; i++) begin
            bits[i] = 1'b0;
            if (i < int'(len)) begin
                ones_odd = ones_odd ^ word[i];
                if (msb_first)
                    bits[i] = word[int'(len) - 1 - i];
                else
                    bits[i] = word[i];
            end
        end

        par_en  = 1'b1;
        par_bit = 1'b0;
        unique case (par_mode)
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_EVEN:  par_bit = ones_odd;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_en  = 1'b0;
        endcase
    end
endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);

    // R3: each bit time runs down one clock at a time
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int DIV_W = 16,
    parameter int MAXB  = 9,
    parameter int MINB  = 5,
    localparam int LW   = $clog2(MAXB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MAXB-1:0]  in_data,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [LW-1:0]    cfg_len,
    input  logic [2:0]       cfg_parity,
    input  logic [1:0]       cfg_stop,
    input  logic             cfg_msb_first,
    input  logic             cfg_inv_line,
    input  logic             cfg_inv_data,
    output logic             tx_out,
    output logic             busy
);
    import sft_pkg::*;

    localparam int CW = DIV_W + 1;

    tx_state_t        state, nxt;
    logic [MAXB-1:0]  shreg;
    logic [LW-1:0]    len_q, bit_idx;
    logic             par_en_q, par_bit_q, inv_line_q, inv_data_q;
    logic [DIV_W-1:0] div_q, div_eff;
    logic [CW-1:0]    stop_q, stop_eff;

    logic [MAXB-1:0]  prep_bits;
    logic [LW-1:0]    prep_len;
    logic             prep_par_en, prep_par_bit;

    logic             accept, tmr_load, tmr_exp;
    logic [CW-1:0]    tmr_val, tmr_cnt;

    sft_word_prep #(.MAXB(MAXB), .MINB(MINB)) u_prep (
        .word     (in_data),
        .len_req  (cfg_len),
        .msb_first(cfg_msb_first),
        .par_mode (cfg_parity),
        .bits     (prep_bits),
        .len      (prep_len),
        .par_en   (prep_par_en),
        .par_bit  (prep_par_bit)
    );

    sft_bit_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .cnt     (tmr_cnt),
        .expire  (tmr_exp)
    );

    assign in_ready = (state == S_IDLE);
    assign busy     = (state != S_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        div_eff = (cfg_div < DIV_W'(2)) ? DIV_W'(2) : cfg_div;
        unique case (cfg_stop)
            STOP_ONE:      stop_eff = {1'b0, div_eff};
            STOP_ONE_HALF: stop_eff = {1'b0, div_eff} + {2'b0, div_eff[DIV_W-1:1]};
            STOP_TWO:      stop_eff = {div_eff, 1'b0};
            default:       stop_eff = {2'b0, div_eff[DIV_W-1:1]};
        endcase
    end

    // next state and bit timer reload
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: if (accept) begin
                nxt      = S_START;
                tmr_load = 1'b1;
                tmr_val  = {1'b0, div_eff} - 1'b1;
            end
            S_START: if (tmr_exp) begin
                nxt      = S_DATA;
                tmr_load = 1'b1;
                tmr_val  = {1'b0, div_q} - 1'b1;
            end
            S_DATA: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (bit_idx != len_q - 1'b1) begin
                    tmr_val = {1'b0, div_q} - 1'b1;
                end else if (par_en_q) begin
                    nxt     = S_PARITY;
                    tmr_val = {1'b0, div_q} - 1'b1;
                end else begin
                    nxt     = S_STOP;
                    tmr_val = stop_q - 1'b1;
                end
            end
            S_PARITY: if (tmr_exp) begin
                nxt      = S_STOP;
                tmr_load = 1'b1;
                tmr_val  = stop_q - 1'b1;
            end
            S_STOP: if (tmr_exp) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and per-frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            shreg      <= '0;
            len_q      <= LW'(MINB);
            bit_idx    <= '0;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            inv_line_q <= 1'b0;
            inv_data_q <= 1'b0;
            div_q      <= DIV_W'(2);
            stop_q     <= CW'(2);
        end else begin
            state <= nxt;
            if (accept) begin
                shreg      <= prep_bits;
                len_q      <= prep_len;
                bit_idx    <= '0;
                par_en_q   <= prep_par_en;
                par_bit_q  <= prep_par_bit;
                inv_line_q <= cfg_inv_line;
                inv_data_q <= cfg_inv_data;
                div_q      <= div_eff;
                stop_q     <= stop_eff;
            end else if (state == S_DATA && tmr_exp) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // line level
    always_comb begin
        unique case (state)
            S_IDLE:   tx_out = ~cfg_inv_line;
            S_START:  tx_out = inv_line_q;
            S_DATA:   tx_out = shreg[0] ^ inv_data_q ^ inv_line_q;
            S_PARITY: tx_out = par_bit_q ^ inv_data_q ^ inv_line_q;
            S_STOP:   tx_out = ~inv_line_q;
            default:  tx_out = ~cfg_inv_line;
        endcase
    end

    // R2: start level appears in the cycle after acceptance
    a_r2_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && tx_out == $past(cfg_inv_line)));

    // R3: data phase ends only after the last configured bit
    a_r3_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_DATA && state != S_DATA) |-> $past(bit_idx) == len_q - 1'b1);

    // R8: end of stop period frees the input
    a_r8_ready_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP && tmr_exp) |=> in_ready);

    // R9: captured configuration holds during a frame
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(len_q) && $stable(div_q) && $stable(stop_q)
            && $stable(par_en_q) && $stable(par_bit_q) && $stable(inv_line_q) && $stable(inv_data_q)));

    // R10: first bit time is never shorter than two clocks
    a_r10_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> tmr_cnt != '0);
endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_data = '0;
    logic [15:0] cfg_div = 16'd4;
    logic [3:0]  cfg_len = 4'd8;
    logic [2:0]  cfg_parity = 3'd0;
    logic [1:0]  cfg_stop = 2'd0;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_inv_line = 1'b0;
    logic        cfg_inv_data = 1'b0;
    logic        tx_out;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;
    bit exp_q[$];
    string tag_q[$];

    serial_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
        .cfg_inv_line(cfg_inv_line), .cfg_inv_data(cfg_inv_data),
        .tx_out(tx_out), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: one expected line level per clock while a frame is due
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (exp_q.size() > 0) begin
                bit lvl;
                string tg;
                lvl = exp_q.pop_front();
                tg  = tag_q.pop_front();
                chk(busy == 1'b1 && in_ready == 1'b0, {"R8 busy during frame ", tg}, int'(busy), 1);
                chk(tx_out == lvl, tg, int'(tx_out), int'(lvl));
            end else begin
                chk(busy == 1'b0 && in_ready == 1'b1, "R8 idle handshake", int'(busy), 0);
                chk(tx_out == ~cfg_inv_line, "R1 idle level", int'(tx_out), int'(~cfg_inv_line));
            end
        end
    end

    task automatic push(input bit lvl, input int n, input string tg);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(lvl);
            tag_q.push_back(tg);
        end
    endtask

    task automatic send(input logic [8:0] d, input int len, input int par, input int stop,
                        input bit msb, input bit invl, input bit invd, input int div,
                        input string tg);
        int L, D, S, ones;
        bit pb;
        L = (len < 5) ? 5 : ((len > 9) ? 9 : len);
        D = (div < 2) ? 2 : div;
        case (stop)
            0: S = D;
            1: S = D + D / 2;
            2: S = 2 * D;
            default: S = D / 2;
        endcase
        @(negedge clk);
        in_data = d; cfg_len = 4'(len); cfg_parity = 3'(par); cfg_stop = 2'(stop);
        cfg_msb_first = msb; cfg_inv_line = invl; cfg_inv_data = invd; cfg_div = 16'(div);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        push(invl, D, {"R2 start ", tg});
        ones = 0;
        for (int i = 0; i < L; i++) begin
            bit b;
            b = msb ? d[L - 1 - i] : d[i];
            ones += int'(d[i]);
            push(b ^ invd ^ invl, D, {"R3 data ", tg});
        end
        if (par >= 1 && par <= 4) begin
            case (par)
                1: pb = (ones % 2 == 0);
                2: pb = (ones % 2 == 1);
                3: pb = 1'b1;
                default: pb = 1'b0;
            endcase
            push(pb ^ invd ^ invl, D, {"R5 parity ", tg});
        end
        push(~invl, S, {"R6 stop ", tg});
        // R9/R8: scramble configuration and keep offering a different word mid-frame
        in_data = ~d; cfg_len = 4'(len + 3); cfg_parity = 3'(par + 1); cfg_stop = 2'(stop + 1);
        cfg_msb_first = ~msb; cfg_inv_data = ~invd; cfg_div = 16'(div + 5);
        while (exp_q.size() > 3) @(negedge clk);
        in_valid = 1'b0;
        cfg_inv_line = invl;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!fin) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && in_ready == 1'b1 && tx_out == 1'b1, "R1 reset state",
            int'({busy, in_ready, tx_out}), 3);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        send(9'h0A5, 8, 0, 0, 0, 0, 0, 4, "R3 8N1");
        send(9'h013, 5, 1, 0, 1, 0, 0, 3, "R4 msb odd");
        send(9'h1C6, 9, 2, 2, 0, 0, 0, 3, "R5 even two stop");
        send(9'h1FF, 7, 1, 0, 0, 0, 0, 3, "R3 upper bits ignored");
        send(9'h05A, 7, 3, 1, 0, 0, 0, 5, "R6 mark 1.5");
        send(9'h02B, 6, 4, 3, 0, 0, 0, 4, "R6 space half");
        send(9'h0C3, 8, 2, 0, 0, 1, 0, 4, "R7 line inv");
        send(9'h03C, 8, 1, 0, 0, 0, 1, 3, "R7 data inv");
        send(9'h155, 9, 1, 1, 1, 1, 1, 2, "R7 both inv msb");
        send(9'h066, 8, 0, 3, 0, 0, 0, 0, "R10 div zero");
        send(9'h099, 8, 2, 3, 0, 0, 0, 1, "R10 div one");
        send(9'h0F1, 3, 2, 0, 0, 0, 0, 2, "R3 len clamp low");
        send(9'h1A7, 15, 1, 0, 1, 0, 0, 2, "R3 len clamp high");
        send(9'h011, 6, 6, 3, 0, 0, 0, 3, "R5 reserved code");
        send(9'h0E4, 8, 1, 2, 0, 0, 0, 3, "R9 cfg change mid frame");
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule